// File: doc/BRIEF.md
# Length-Prefixed Packet Receiver

This block sits after a serial byte receiver and turns a stream of bytes into stored packets. Each byte arrives with a one-cycle valid strobe. The first byte of a packet is a length value L. It is followed by L payload bytes and then two checksum bytes, high byte first. The block writes the length byte and every payload byte into an external byte-wide RAM through a simple write port. The length byte goes to a fixed base address, and the payload bytes go to the addresses that follow it.

A run-time counter decides when the payload ends. The counter has its own enable and is compared against the length byte. There is no fixed loop bound, so a packet may carry from zero to 255 payload bytes. After the low checksum byte, the block compares the received 16-bit value with the sum of the payload bytes. It then raises a one-cycle done pulse on a match, or a one-cycle error pulse otherwise, and waits for the next length byte.

Top module: `pkt_len_rx`

## Requirements
- R1: After a synchronous active-low reset, the write strobe, done and error are all low, and the next strobed byte is taken as a length byte.
- R2: A cycle without the byte strobe writes nothing, raises neither done nor error, and leaves the position in the packet unchanged.
- R3: The length byte is written to RAM address 3 in the same cycle that it is strobed, with its own value as the write data.
- R4: Payload byte k (counted from 0) is written, in the cycle it is strobed, to address (4 + k) modulo 2^ADDR_W, with the byte as the write data.
- R5: Exactly L payload bytes are accepted; the byte after the L-th payload byte is treated as the high checksum byte. L is an 8-bit unsigned value, so L = 255 is valid.
- R6: A length of zero sends the machine straight to the checksum bytes, with no payload write.
- R7: The two checksum bytes (high byte first) are never written to RAM.
- R8: When the checksum {high, low} equals the 16-bit modulo sum of the payload bytes, done is high for exactly one cycle: the cycle after the low checksum byte is strobed. Error stays low.
- R9: When the checksum differs from that sum, error is high for exactly that one cycle, and done stays low.
- R10: The byte that follows the low checksum byte starts a new packet as its length byte.
- R11: A reset in the middle of a packet drops that packet; the next byte is a length byte again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | DATA_W | Received byte |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | DATA_W | RAM write data |
| done | output | 1 | Pulse: packet complete, checksum matched |
| err | output | 1 | Pulse: packet complete, checksum mismatched |

## Verification
The assertions assume that reset is held through at least one clock edge before the first byte. They also assume that the strobe is meaningful only on clock edges. From that they derive that any write must coincide with a strobe, that done and error can only follow a strobed byte, and that writes on back-to-back cycles step the address by one. The stimulus changes inputs only just after a rising edge and samples just before the next one. It sends packets back to back, with idle gaps, with zero and maximum lengths, and with a reset dropped into an unfinished packet.

// File: rtl/pkt_rx_pkg.sv
// Shared types for the length-prefixed packet receiver.
package pkt_rx_pkg;
    // Position within the packet; ST_LEN is also the idle state.
    typedef enum logic [1:0] {
        ST_LEN  = 2'd0,
        ST_DATA = 2'd1,
        ST_CKH  = 2'd2,
        ST_CKL  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/pkt_rx_ctrl.sv
// Packet state machine. Next state is purely combinational and
// produces one accept strobe per packet field. Assumes cnt and len come
// from pkt_rx_count and hold the payload count and the stored length.
module pkt_rx_ctrl
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] len,
    output rx_state_e         st,
    output logic              len_acc,
    output logic              pay_acc,
    output logic              ckh_acc,
    output logic              ckl_acc
);
    rx_state_e nxt;
    logic      more_pay;

    // Another payload byte is due when the count after this byte is below the length.
    assign more_pay = ({1'b0, cnt} + {{DATA_W{1'b0}}, 1'b1}) < {1'b0, len};

    // Next-state and accept-strobe decode; hold state when no byte arrives.
    always_comb begin
        nxt     = st;
        len_acc = 1'b0;
        pay_acc = 1'b0;
        ckh_acc = 1'b0;
        ckl_acc = 1'b0;
        if (rx_valid) begin
            case (st)
                ST_LEN: begin
                    len_acc = 1'b1;
                    nxt     = (rx_byte == '0) ? ST_CKH : ST_DATA;
                end
                ST_DATA: begin
                    pay_acc = 1'b1;
                    nxt     = more_pay ? ST_DATA : ST_CKH;
                end
                ST_CKH: begin
                    ckh_acc = 1'b1;
                    nxt     = ST_CKL;
                end
                default: begin
                    ckl_acc = 1'b1;
                    nxt     = ST_LEN;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LEN;
        else        st <= nxt;
    end
endmodule

// File: rtl/pkt_rx_count.sv
// Payload byte counter and stored length. The counter has its own clear
// and increment enables; assumes clr and inc are never high together.
module pkt_rx_count #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [DATA_W-1:0] len_in,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] len
);
    // Payload counter: cleared on the length byte, stepped per payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + {{(DATA_W-1){1'b0}}, 1'b1};
    end

    // Length register, loaded when the length byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)   len <= '0;
        else if (clr) len <= len_in;
    end
endmodule

// File: rtl/pkt_rx_csum.sv
// Running payload sum and end-of-packet compare. Assumes the strobes
// arrive in packet order: clr, any number of add, hi_ld, then lo_chk.
module pkt_rx_csum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic              hi_ld,
    input  logic              lo_chk,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic              err
);
    localparam int SUM_W = 2 * DATA_W;

    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] hi_q;
    logic              match;

    assign match = ({hi_q, din} == sum);

    // Modulo payload sum.
    always_ff @(posedge clk) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (add) sum <= sum + {{DATA_W{1'b0}}, din};
    end

    // Holds the high checksum byte until the low byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_ld) hi_q <= din;
    end

    // One-cycle result pulses after the low checksum byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= lo_chk & match;
            err  <= lo_chk & ~match;
        end
    end
endmodule

// File: rtl/pkt_len_rx.sv
// Top of the length-prefixed packet receiver. Writes the length byte and
// the payload to an external RAM through a same-cycle write port and
// reports the checksum result. Assumes rx_valid lasts one cycle per byte.
module pkt_len_rx
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int LEN_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(LEN_ADDR);
    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(LEN_ADDR + 1);

    rx_state_e         st;
    logic              len_acc, pay_acc, ckh_acc, ckl_acc;
    logic [DATA_W-1:0] cnt, len;

    pkt_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cnt(cnt), .len(len), .st(st),
        .len_acc(len_acc), .pay_acc(pay_acc), .ckh_acc(ckh_acc), .ckl_acc(ckl_acc)
    );

    pkt_rx_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(len_acc), .inc(pay_acc),
        .len_in(rx_byte), .cnt(cnt), .len(len)
    );

    pkt_rx_csum #(.DATA_W(DATA_W)) u_csum (
        .clk(clk), .rst_n(rst_n), .clr(len_acc), .add(pay_acc),
        .hi_ld(ckh_acc), .lo_chk(ckl_acc), .din(rx_byte),
        .done(done), .err(err)
    );

    // RAM write port: length byte at the base, payload right after it.
    always_comb begin
        wr_en   = len_acc | pay_acc;
        wr_data = rx_byte;
        wr_addr = (st == ST_LEN) ? BASE_A : FIRST_A + ADDR_W'(cnt);
    end
endmodule

// File: rtl/pkt_len_rx_chk.sv
// Port-level checker for pkt_len_rx, attached with bind below.
module pkt_len_rx_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done,
    input logic              err
);
    AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rx_valid);  // R2
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));  // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);  // R9
    AST_RESULT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err) && $past(rst_n)) |-> $past(rx_valid));  // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && $past(rst_n)) |-> (wr_addr == $past(wr_addr) + 1'b1));  // R4
endmodule

bind pkt_len_rx pkt_len_rx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .done(done), .err(err)
);

// File: tb/pkt_len_rx_tb_top.sv
`timescale 1ns/1ps
// Directed bench for pkt_len_rx: one task per scenario.
module pkt_len_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       wr_en, done, err;
    logic [7:0] wr_addr, wr_data;
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pkt_len_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called just after a rising edge; leaves just after the next one.
    task automatic put_byte(input logic [7:0] b, input bit exp_wr,
                            input logic [7:0] exp_addr, input string req);
        rx_valid = 1'b1;
        rx_byte  = b;
        #8;
        check(wr_en == exp_wr, req, "wr_en", int'(wr_en), int'(exp_wr));
        if (exp_wr) begin
            check(wr_addr == exp_addr, req, "wr_addr", int'(wr_addr), int'(exp_addr));
            check(wr_data == b, req, "wr_data", int'(wr_data), int'(b));
        end
        @(posedge clk); #2;
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            #8;
            check(!wr_en && !done && !err, req, "idle outputs",
                  int'({wr_en, done, err}), 0);
            @(posedge clk); #2;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // Full packet; payload byte i = seed + 7*i; bad flips the low checksum bit.
    task automatic run_packet(input int len, input logic [7:0] seed, input bit bad,
                              input int gap, input string req);
        logic [15:0] sum = 16'h0;
        logic [7:0]  pb;
        put_byte(8'(len), 1'b1, 8'd3, "R3");
        if (gap > 0) idle(gap, "R2");
        for (int i = 0; i < len; i++) begin
            pb  = seed + 8'(7 * i);
            sum = sum + {8'h00, pb};
            put_byte(pb, 1'b1, 8'(4 + i), "R4");
            if (gap > 0) idle(gap, "R2");
        end
        put_byte(sum[15:8], 1'b0, 8'h00, (len == 0) ? "R6" : "R5");
        put_byte(sum[7:0] ^ {7'b0, bad}, 1'b0, 8'h00, "R7");
        #8;
        if (bad) check(err && !done, req, "err pulse R9", int'({done, err}), 1);
        else     check(done && !err, req, "done pulse R8", int'({done, err}), 2);
        @(posedge clk); #2;
        #8;
        check(!done && !err, req, "pulse width R8 R9", int'({done, err}), 0);
        @(posedge clk); #2;
    endtask

    task automatic t_reset();
        do_reset();
        #8;
        check(!wr_en && !done && !err, "R1", "outputs after reset",
              int'({wr_en, done, err}), 0);
        @(posedge clk); #2;
        run_packet(1, 8'h55, 1'b0, 0, "R1");
    endtask

    task automatic t_basic();   run_packet(3, 8'hA1, 1'b0, 0, "R5");   endtask
    task automatic t_gaps();    run_packet(4, 8'h10, 1'b0, 2, "R2");   endtask
    task automatic t_zero();    run_packet(0, 8'h00, 1'b0, 0, "R6");   endtask
    task automatic t_bad();     run_packet(5, 8'h3C, 1'b1, 0, "R9");   endtask
    task automatic t_max();     run_packet(255, 8'hF0, 1'b0, 0, "R8"); endtask

    task automatic t_back_to_back();
        run_packet(2, 8'h01, 1'b0, 0, "R10");
        run_packet(6, 8'h80, 1'b1, 0, "R10");
        run_packet(1, 8'hFF, 1'b0, 0, "R10");
    endtask

    task automatic t_mid_reset();
        put_byte(8'd5, 1'b1, 8'd3, "R11");
        put_byte(8'h11, 1'b1, 8'd4, "R11");
        put_byte(8'h22, 1'b1, 8'd5, "R11");
        do_reset();
        run_packet(2, 8'h40, 1'b0, 0, "R11");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_zero();
        t_bad();
        t_max();
        t_back_to_back();
        t_mid_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule